// File: doc/BRIEF.md
# Accumulator Register-Reference Unit

This unit executes the two operand-free instruction groups of a 16-bit accumulator machine: the register group, which clears, complements, rotates, increments and tests the accumulator (AC) and its carry bit E, and the input/output group, which moves characters between AC and the 8-bit input and output registers, tests the device flags and switches interrupts on or off. The unit owns the AC and E registers. It also applies the memory-reference results that end in AC: a plain load, a bitwise AND and an add whose carry-out lands in E.

The sequencer marks that the fetched instruction belongs to one of the two groups (`exec_i`) and gives the mode bit (`io_grp_i`). On the execute step strobe `t3_i`, the unit decodes the low 12 instruction bits. Only the most significant set bit acts. The unit updates AC and E on the next clock edge. During the strobe cycle it raises the control requests for the rest of the machine: skip (increment PC), halt, output-register load, flag clears, interrupt-enable set or clear, and sequence-counter reset.

Top module: `acc_rr_unit`

## Requirements
- R1: While `rst_ni` is low, AC and E are 0.
- R2: In the register group, field bit 11 clears AC, bit 10 clears E, bit 9 inverts every bit of AC and bit 8 inverts E. The result is visible after the next clock edge.
- R3: In the register group, field bit 7 rotates the 17-bit value {E, AC} right by one: E goes to AC bit 15 and AC bit 0 goes to E.
- R4: In the register group, field bit 6 rotates left by one: E goes to AC bit 0 and AC bit 15 goes to E.
- R5: In the register group, field bit 5 adds 1 to AC modulo 2^16 and leaves E unchanged.
- R6: In the register group, `skip_o` is high in the strobe cycle under these conditions: bit 4 when AC bit 15 is 0, bit 3 when AC bit 15 is 1, bit 2 when AC is zero, and bit 1 when E is 0.
- R7: In the register group, field bit 0 raises `halt_o` in the strobe cycle.
- R8: When several field bits are set, only the highest set bit acts. All lower bits have no effect on AC, E or any control output.
- R9: In the I/O group, field bit 11 loads `inpr_i` into AC bits 7:0, keeps AC bits 15:8, and raises `fgi_clr_o`.
- R10: In the I/O group, field bit 10 raises `outr_load_o` and `fgo_clr_o` with `outr_o` equal to AC bits 7:0, and leaves AC unchanged.
- R11: In the I/O group, bit 9 skips when `fgi_i` is 1, bit 8 skips when `fgo_i` is 1, bit 7 raises `ien_set_o` and bit 6 raises `ien_clr_o`.
- R12: Unless `t3_i` and `exec_i` are both high, every control output is low. With no memory-reference request also present, AC and E keep their values.
- R13: Outside a group strobe, `mem_add_i` sets {E, AC} to AC + `dr_i` with the carry-out in E. `mem_and_i` sets AC to AC & `dr_i`. `mem_ld_i` sets AC to `dr_i`. Priority among these three is add, then AND, then load.
- R14: Every group strobe raises `sc_clr_o`, including one with an all-zero field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t3_i | input | 1 | Execute step strobe |
| exec_i | input | 1 | Instruction is in the register or I/O group |
| io_grp_i | input | 1 | Mode bit: 0 register group, 1 I/O group |
| ir_i | input | 12 | Low instruction field, one bit per operation |
| inpr_i | input | 8 | Input register character |
| fgi_i | input | 1 | Input flag |
| fgo_i | input | 1 | Output flag |
| mem_ld_i | input | 1 | Load `dr_i` into AC |
| mem_and_i | input | 1 | AND `dr_i` into AC |
| mem_add_i | input | 1 | Add `dr_i` to AC, carry to E |
| dr_i | input | 16 | Memory operand |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry bit E |
| skip_o | output | 1 | Request to increment PC |
| halt_o | output | 1 | Halt request |
| sc_clr_o | output | 1 | Sequence counter reset |
| outr_load_o | output | 1 | Load output register |
| outr_o | output | 8 | Output register data |
| fgi_clr_o | output | 1 | Clear input flag |
| fgo_clr_o | output | 1 | Clear output flag |
| ien_set_o | output | 1 | Set interrupt enable |
| ien_clr_o | output | 1 | Clear interrupt enable |

## Verification
On every cycle, the assertions check these properties: the control outputs stay quiet without a strobe, AC and E hold when nothing is requested, the sequence reset comes with each strobe, at most one control request is raised at a time, the output load carries AC bits 7:0 with the flag clear, and the right rotate and increment give the correct results. The bench scenarios cover the remaining behaviour: the value-dependent skip tests, the left rotate and complements, the highest-bit priority with mixed fields, the input merge into the low byte, the carry from the add path and the all-zero field. The bench computes each result from a model of the requirements and compares it in the strobe cycle and after the following edge.

// File: rtl/acc_rr_pkg.sv
package acc_rr_pkg;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int IR_W   = 12;

  // register group bit positions (priority order, high wins)
  localparam int B_CLA = IR_W - 1;
  localparam int B_CLE = IR_W - 2;
  localparam int B_CMA = IR_W - 3;
  localparam int B_CME = IR_W - 4;
  localparam int B_CIR = IR_W - 5;
  localparam int B_CIL = IR_W - 6;
  localparam int B_INC = IR_W - 7;
  localparam int B_SPA = IR_W - 8;
  localparam int B_SNA = IR_W - 9;
  localparam int B_SZA = IR_W - 10;
  localparam int B_SZE = IR_W - 11;
  localparam int B_HLT = IR_W - 12;

  // I/O group uses the top six bits
  localparam int IO_N  = 6;
  localparam int B_INP = 5;
  localparam int B_OUT = 4;
  localparam int B_SKI = 3;
  localparam int B_SKO = 2;
  localparam int B_ION = 1;
  localparam int B_IOF = 0;
endpackage

// File: rtl/acc_rr_prio.sv
module acc_rr_prio #(
  parameter int W = acc_rr_pkg::IR_W
) (
  input  logic [W-1:0] field_i,
  output logic [W-1:0] sel_o
);
  logic [W:0] above;
  assign above[W] = 1'b0;

  for (genvar gi = W - 1; gi >= 0; gi--) begin : g_bit
    assign sel_o[gi] = field_i[gi] & ~above[gi+1];
    assign above[gi] = above[gi+1] | field_i[gi];
  end
endmodule

// File: rtl/acc_rr_regops.sv
module acc_rr_regops
  import acc_rr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [IR_W-1:0] sel_i,
  input  logic [DW-1:0]   ac_i,
  input  logic            e_i,
  output logic [DW-1:0]   ac_nx_o,
  output logic            e_nx_o,
  output logic            skip_o,
  output logic            halt_o
);
  always_comb begin
    ac_nx_o = ac_i;
    e_nx_o  = e_i;
    if (sel_i[B_CLA]) ac_nx_o = '0;
    if (sel_i[B_CLE]) e_nx_o  = 1'b0;
    if (sel_i[B_CMA]) ac_nx_o = ~ac_i;
    if (sel_i[B_CME]) e_nx_o  = ~e_i;
    if (sel_i[B_CIR]) begin
      ac_nx_o = {e_i, ac_i[DW-1:1]};
      e_nx_o  = ac_i[0];
    end
    if (sel_i[B_CIL]) begin
      ac_nx_o = {ac_i[DW-2:0], e_i};
      e_nx_o  = ac_i[DW-1];
    end
    if (sel_i[B_INC]) ac_nx_o = ac_i + DW'(1);
  end

  assign skip_o = (sel_i[B_SPA] & ~ac_i[DW-1])
                | (sel_i[B_SNA] &  ac_i[DW-1])
                | (sel_i[B_SZA] & (ac_i == '0))
                | (sel_i[B_SZE] & ~e_i);
  assign halt_o = sel_i[B_HLT];
endmodule

// File: rtl/acc_rr_ioops.sv
module acc_rr_ioops
  import acc_rr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHAR_W
) (
  input  logic [IO_N-1:0] sel_i,
  input  logic [DW-1:0]   ac_i,
  input  logic [CW-1:0]   inpr_i,
  input  logic            fgi_i,
  input  logic            fgo_i,
  output logic [DW-1:0]   ac_nx_o,
  output logic            skip_o,
  output logic            outr_load_o,
  output logic [CW-1:0]   outr_o,
  output logic            fgi_clr_o,
  output logic            fgo_clr_o,
  output logic            ien_set_o,
  output logic            ien_clr_o
);
  assign ac_nx_o     = sel_i[B_INP] ? {ac_i[DW-1:CW], inpr_i} : ac_i;
  assign fgi_clr_o   = sel_i[B_INP];
  assign outr_load_o = sel_i[B_OUT];
  assign fgo_clr_o   = sel_i[B_OUT];
  assign outr_o      = ac_i[CW-1:0];
  assign skip_o      = (sel_i[B_SKI] & fgi_i) | (sel_i[B_SKO] & fgo_i);
  assign ien_set_o   = sel_i[B_ION];
  assign ien_clr_o   = sel_i[B_IOF];
endmodule

// File: rtl/acc_rr_unit.sv
module acc_rr_unit
  import acc_rr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              t3_i,
  input  logic              exec_i,
  input  logic              io_grp_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic [CHAR_W-1:0] inpr_i,
  input  logic              fgi_i,
  input  logic              fgo_i,
  input  logic              mem_ld_i,
  input  logic              mem_and_i,
  input  logic              mem_add_i,
  input  logic [DATA_W-1:0] dr_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              sc_clr_o,
  output logic              outr_load_o,
  output logic [CHAR_W-1:0] outr_o,
  output logic              fgi_clr_o,
  output logic              fgo_clr_o,
  output logic              ien_set_o,
  output logic              ien_clr_o
);
  logic [DATA_W-1:0] ac_q, ac_d, rr_ac, io_ac;
  logic              e_q, e_d, rr_e;
  logic [IR_W-1:0]   sel;
  logic              go, go_rr, go_io;
  logic              rr_skip, rr_halt, io_skip;
  logic              io_oload, io_fgic, io_fgoc, io_iens, io_ienc;
  logic [DATA_W:0]   sum;

  assign go    = t3_i & exec_i;
  assign go_rr = go & ~io_grp_i;
  assign go_io = go &  io_grp_i;

  acc_rr_prio #(.W(IR_W)) u_prio (
    .field_i(ir_i),
    .sel_o  (sel)
  );

  acc_rr_regops #(.DW(DATA_W)) u_reg (
    .sel_i  (sel),
    .ac_i   (ac_q),
    .e_i    (e_q),
    .ac_nx_o(rr_ac),
    .e_nx_o (rr_e),
    .skip_o (rr_skip),
    .halt_o (rr_halt)
  );

  acc_rr_ioops #(.DW(DATA_W), .CW(CHAR_W)) u_io (
    .sel_i      (sel[IR_W-1 -: IO_N]),
    .ac_i       (ac_q),
    .inpr_i     (inpr_i),
    .fgi_i      (fgi_i),
    .fgo_i      (fgo_i),
    .ac_nx_o    (io_ac),
    .skip_o     (io_skip),
    .outr_load_o(io_oload),
    .outr_o     (outr_o),
    .fgi_clr_o  (io_fgic),
    .fgo_clr_o  (io_fgoc),
    .ien_set_o  (io_iens),
    .ien_clr_o  (io_ienc)
  );

  assign sum = {1'b0, ac_q} + {1'b0, dr_i};

  always_comb begin
    ac_d = ac_q;
    e_d  = e_q;
    if (go_rr) begin
      ac_d = rr_ac;
      e_d  = rr_e;
    end else if (go_io) begin
      ac_d = io_ac;
    end else if (mem_add_i) begin
      {e_d, ac_d} = sum;
    end else if (mem_and_i) begin
      ac_d = ac_q & dr_i;
    end else if (mem_ld_i) begin
      ac_d = dr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
      e_q  <= 1'b0;
    end else begin
      ac_q <= ac_d;
      e_q  <= e_d;
    end
  end

  assign ac_o        = ac_q;
  assign e_o         = e_q;
  assign sc_clr_o    = go;
  assign skip_o      = (go_rr & rr_skip) | (go_io & io_skip);
  assign halt_o      = go_rr & rr_halt;
  assign outr_load_o = go_io & io_oload;
  assign fgi_clr_o   = go_io & io_fgic;
  assign fgo_clr_o   = go_io & io_fgoc;
  assign ien_set_o   = go_io & io_iens;
  assign ien_clr_o   = go_io & io_ienc;
endmodule

// File: rtl/acc_rr_checker.sv
module acc_rr_checker
  import acc_rr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              t3_i,
  input logic              exec_i,
  input logic              io_grp_i,
  input logic [IR_W-1:0]   ir_i,
  input logic              mem_ld_i,
  input logic              mem_and_i,
  input logic              mem_add_i,
  input logic [DATA_W-1:0] ac_o,
  input logic              e_o,
  input logic              skip_o,
  input logic              halt_o,
  input logic              sc_clr_o,
  input logic              outr_load_o,
  input logic [CHAR_W-1:0] outr_o,
  input logic              fgi_clr_o,
  input logic              fgo_clr_o,
  input logic              ien_set_o,
  input logic              ien_clr_o
);
  logic strobe;
  assign strobe = t3_i && exec_i;

  assert_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |-> !(skip_o || halt_o || sc_clr_o || outr_load_o || fgi_clr_o ||
                  fgo_clr_o || ien_set_o || ien_clr_o));

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && !mem_ld_i && !mem_and_i && !mem_add_i) |=> ($stable(ac_o) && $stable(e_o)));

  assert_seq_reset_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> sc_clr_o);

  assert_single_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({skip_o, halt_o, outr_load_o, fgi_clr_o, ien_set_o, ien_clr_o}));

  assert_out_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outr_load_o |-> (fgo_clr_o && outr_o == ac_o[CHAR_W-1:0]));

  assert_rotate_right_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !io_grp_i && ir_i == IR_W'(1 << B_CIR))
      |=> (ac_o == {$past(e_o), $past(ac_o[DATA_W-1:1])} && e_o == $past(ac_o[0])));

  assert_increment_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !io_grp_i && ir_i == IR_W'(1 << B_INC))
      |=> (ac_o == $past(ac_o) + DATA_W'(1) && e_o == $past(e_o)));
endmodule

bind acc_rr_unit acc_rr_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .t3_i       (t3_i),
  .exec_i     (exec_i),
  .io_grp_i   (io_grp_i),
  .ir_i       (ir_i),
  .mem_ld_i   (mem_ld_i),
  .mem_and_i  (mem_and_i),
  .mem_add_i  (mem_add_i),
  .ac_o       (ac_o),
  .e_o        (e_o),
  .skip_o     (skip_o),
  .halt_o     (halt_o),
  .sc_clr_o   (sc_clr_o),
  .outr_load_o(outr_load_o),
  .outr_o     (outr_o),
  .fgi_clr_o  (fgi_clr_o),
  .fgo_clr_o  (fgo_clr_o),
  .ien_set_o  (ien_set_o),
  .ien_clr_o  (ien_clr_o)
);

// File: tb/tb_acc_rr_unit.sv
`timescale 1ns/1ps
module tb_acc_rr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        t3_i = 0, exec_i = 0, io_grp_i = 0;
  logic [11:0] ir_i = '0;
  logic [7:0]  inpr_i = '0;
  logic        fgi_i = 0, fgo_i = 0;
  logic        mem_ld_i = 0, mem_and_i = 0, mem_add_i = 0;
  logic [15:0] dr_i = '0;
  logic [15:0] ac_o;
  logic        e_o, skip_o, halt_o, sc_clr_o, outr_load_o;
  logic [7:0]  outr_o;
  logic        fgi_clr_o, fgo_clr_o, ien_set_o, ien_clr_o;

  always #5 clk_i = ~clk_i;

  acc_rr_unit dut (.*);

  typedef struct {
    string       tag;
    logic [7:0]  ctl;
    logic [7:0]  outr;
    logic [15:0] ac;
    logic        e;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  logic [15:0] m_ac = '0;
  logic        m_e  = 1'b0;
  bit          done = 0;

  // ctl order: skip halt sc_clr outr_load fgi_clr fgo_clr ien_set ien_clr
  task automatic step(string tag, bit t3, bit ex, bit io, logic [11:0] ir,
                      bit ld, bit an, bit ad, logic [15:0] d,
                      logic [7:0] inp, bit gi, bit go);
    exp_t x;
    int   h;
    logic [7:0] c;
    @(negedge clk_i); #1;
    t3_i = t3; exec_i = ex; io_grp_i = io; ir_i = ir;
    mem_ld_i = ld; mem_and_i = an; mem_add_i = ad; dr_i = d;
    inpr_i = inp; fgi_i = gi; fgo_i = go;
    c = '0; h = -1;
    for (int i = 11; i >= 0; i--) if (h < 0 && ir[i]) h = i;
    x.outr = m_ac[7:0];
    if (t3 && ex) begin
      c[5] = 1'b1;
      if (!io) begin
        case (h)
          11: m_ac = '0;
          10: m_e = 1'b0;
          9:  m_ac = ~m_ac;
          8:  m_e = ~m_e;
          7:  begin logic b; b = m_ac[0]; m_ac = {m_e, m_ac[15:1]}; m_e = b; end
          6:  begin logic b; b = m_ac[15]; m_ac = {m_ac[14:0], m_e}; m_e = b; end
          5:  m_ac = m_ac + 16'd1;
          4:  c[7] = !m_ac[15];
          3:  c[7] = m_ac[15];
          2:  c[7] = (m_ac == 0);
          1:  c[7] = !m_e;
          0:  c[6] = 1'b1;
          default: ;
        endcase
      end else begin
        case (h)
          11: begin m_ac[7:0] = inp; c[3] = 1'b1; end
          10: begin c[4] = 1'b1; c[2] = 1'b1; end
          9:  c[7] = gi;
          8:  c[7] = go;
          7:  c[1] = 1'b1;
          6:  c[0] = 1'b1;
          default: ;
        endcase
      end
    end else if (ad) begin
      {m_e, m_ac} = {1'b0, m_ac} + {1'b0, d};
    end else if (an) begin
      m_ac = m_ac & d;
    end else if (ld) begin
      m_ac = d;
    end
    x.tag = tag; x.ctl = c; x.ac = m_ac; x.e = m_e;
    q.push_back(x);
  endtask

  task automatic rr(string tag, logic [11:0] ir);
    step(tag, 1, 1, 0, ir, 0, 0, 0, '0, '0, 0, 0);
  endtask
  task automatic iop(string tag, logic [11:0] ir, logic [7:0] inp, bit gi, bit go);
    step(tag, 1, 1, 1, ir, 0, 0, 0, '0, inp, gi, go);
  endtask
  task automatic load(logic [15:0] d);
    step("R13", 0, 0, 0, '0, 1, 0, 0, d, '0, 0, 0);
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: control outputs in the strobe cycle, registers after the edge
  initial begin
    forever begin
      @(negedge clk_i); #3;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check(x.tag, "ctl",
              {24'd0, skip_o, halt_o, sc_clr_o, outr_load_o, fgi_clr_o, fgo_clr_o,
               ien_set_o, ien_clr_o}, {24'd0, x.ctl});
        if (x.ctl[4]) check(x.tag, "outr", {24'd0, outr_o}, {24'd0, x.outr});
        @(posedge clk_i); #1;
        check(x.tag, "ac", {16'd0, ac_o}, {16'd0, x.ac});
        check(x.tag, "e", {31'd0, e_o}, {31'd0, x.e});
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1", "ac reset", {16'd0, ac_o}, 32'd0);
    check("R1", "e reset", {31'd0, e_o}, 32'd0);
    rst_ni = 1'b1;

    load(16'h1234);
    rr("R2", 12'h800);               // clear AC
    load(16'h00F0);
    rr("R2", 12'h200);               // complement AC
    rr("R2", 12'h100);               // complement E -> 1
    rr("R2", 12'h400);               // clear E
    rr("R2", 12'h100);
    load(16'h0001);
    rr("R3", 12'h080);               // rotate right
    rr("R3", 12'h080);
    load(16'h8000);
    rr("R4", 12'h040);               // rotate left
    rr("R4", 12'h040);
    load(16'hFFFF);
    rr("R5", 12'h020);               // wrap to 0, E kept
    rr("R6", 12'h010);               // AC zero counts as positive
    rr("R6", 12'h004);
    rr("R6", 12'h008);
    rr("R6", 12'h002);
    load(16'h8001);
    rr("R6", 12'h008);
    rr("R6", 12'h010);
    rr("R6", 12'h004);
    rr("R2", 12'h400);
    rr("R6", 12'h002);
    rr("R7", 12'h001);
    rr("R8", 12'h801);               // clear wins, no halt
    load(16'h0003);
    rr("R8", 12'h0C0);               // rotate right wins over left
    rr("R8", 12'h01F);               // skip-positive wins over halt
    load(16'h5500);
    iop("R9", 12'h800, 8'h3C, 0, 0);
    iop("R10", 12'h400, 8'h00, 0, 0);
    iop("R8", 12'hC00, 8'hAA, 0, 0); // input wins over output
    iop("R11", 12'h200, 8'h00, 1, 0);
    iop("R11", 12'h200, 8'h00, 0, 1);
    iop("R11", 12'h100, 8'h00, 0, 1);
    iop("R11", 12'h100, 8'h00, 1, 0);
    iop("R11", 12'h080, 8'h00, 0, 0);
    iop("R11", 12'h040, 8'h00, 0, 0);
    step("R12", 0, 1, 0, 12'h800, 0, 0, 0, '0, '0, 1, 1);
    step("R12", 1, 0, 1, 12'h800, 0, 0, 0, '0, 8'hFF, 1, 1);
    load(16'hFFFF);
    step("R13", 0, 0, 0, '0, 1, 0, 1, 16'h0002, '0, 0, 0); // add wins
    step("R13", 0, 0, 0, '0, 1, 1, 0, 16'h00FF, '0, 0, 0); // AND wins
    step("R12", 1, 1, 0, 12'h200, 0, 0, 1, 16'h1111, '0, 0, 0); // strobe wins
    rr("R14", 12'h000);
    iop("R14", 12'h000, 8'h00, 1, 1);

    @(negedge clk_i); #1;
    t3_i = 0; exec_i = 0; mem_ld_i = 0; mem_and_i = 0; mem_add_i = 0;
    repeat (3) @(posedge clk_i);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule